// File: doc/BRIEF.md
# FEAC Codeword Receiver

This block watches a serial bit stream, one bit for every cycle in which its bit enable is high, and searches it for far-end alarm and control (FEAC) codewords. A codeword is sixteen bits long. In the order the bits arrive it has eight ones, a zero, six payload bits and a final zero. After the block frames a codeword it validates the payload by debouncing it over a short run of codewords. It then places each newly validated payload into a small receive FIFO.

The host sees the block through one 16-bit status word and one interrupt line. It pulses `stat_rd` for one cycle and samples `stat` in that same cycle. The strobe pops the head entry of the FIFO and clears the latched event bits at the following clock edge. The interrupt is formed from the latched flags, a global enable and an idle-specific enable.

Top module: `feac_rx`

## Requirements
- R1: A codeword is framed when the last sixteen enabled bits, in arrival order, are eight ones, a zero, six payload bits and a zero. The first payload bit to arrive becomes payload bit 0. After a frame the framer needs sixteen fresh bits before it can frame again.
- R2: The framer groups codewords into windows, and the first codeword of a window is the candidate. A payload is validated when 8 codewords of a window carry the candidate payload, and a window spans at most 10 codewords. A third mismatch in a window starts a new window, and the mismatching codeword becomes its candidate. A validation also starts a fresh window.
- R3: A validated payload equal to the previously validated payload is not treated as new. It is not pushed and does not set the detect flag. This holds until an idle event occurs, after which the same payload counts as new again.
- R4: Status bit 0, the detect flag, latches when a new payload is validated and clears on a status read.
- R5: Status bit 1, the idle flag, latches when 16 consecutive enabled ones arrive after a validation and clears on a status read. One validation arms only one idle event.
- R6: Status bit 14 is high exactly while the FIFO is empty. While it is high, the payload field (bits 13:8) reads zero.
- R7: The FIFO holds 4 entries in arrival order. Bits 13:8 show the head entry, and a status read pops it. A read of an empty FIFO pops nothing.
- R8: A new payload that arrives while the FIFO is full and not being popped is dropped. It latches status bit 15, which clears on a status read. A push and a pop of a full FIFO in the same cycle are both accepted.
- R9: Status bits 7:2 always read zero.
- R10: `irq` is high when `feac_ie` is high and either the detect flag is set, or the idle flag is set while `idle_ie` is high.
- R11: If a flag's setting event and a status read fall in the same cycle, the flag is set after that edge.
- R12: A synchronous active-high reset empties the FIFO, clears all flags, the framer, the validation window, the idle arming and the previous-payload memory. After reset the status reads 0x4000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial received bit |
| stat_rd | input | 1 | Status read strobe; pops FIFO and clears latched flags |
| idle_ie | input | 1 | Lets the idle flag raise the interrupt |
| feac_ie | input | 1 | Global interrupt enable for this block |
| stat | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
Two things can happen in the same cycle: the bit that completes a validated codeword, which pushes the FIFO and sets the detect flag, and a host status read, which pops and clears. The bench provokes this collision in a directed case that asserts the read strobe on the final bit of the eighth matching codeword. Random reads during codeword streams also produce it, including a push into a full FIFO during a pop. The collision is judged on the next cycle against a bench model. The flag must still be set, the popped entry must be gone and the new payload must have been stored rather than counted as overflow.

// File: rtl/feac_rx.sv
module feac_rx #(
  parameter int DEPTH    = 4,
  parameter int VAL_NEED = 8,
  parameter int VAL_WIN  = 10,
  parameter int IDLE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bit_en,
  input  logic        bit_in,
  input  logic        stat_rd,
  input  logic        idle_ie,
  input  logic        feac_ie,
  output logic [15:0] stat,
  output logic        irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = $clog2(VAL_WIN + 1);
  localparam int OW = $clog2(IDLE_LEN + 1);

  logic [15:0]   sr;
  logic [5:0]    cand, last_pl;
  logic [WW-1:0] hit, tot;
  logic [OW-1:0] ones;
  logic          armed, last_ok;
  logic [5:0]    mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          cfd, idle_f, ovf;

  wire [15:0] nxt = {bit_in, sr[15:1]};
  wire [5:0]  pl  = nxt[14:9];
  wire frame = bit_en && nxt[7:0] == 8'hFF && !nxt[8] && !nxt[15];

  wire           same   = (pl == cand);
  wire [WW-1:0]  hit_n  = (tot == '0) ? WW'(1) : hit + WW'(same);
  wire [WW-1:0]  tot_n  = tot + WW'(1);
  wire [WW-1:0]  miss_n = (tot == '0) ? '0 : tot_n - hit_n;
  wire val     = frame && hit_n == WW'(VAL_NEED);
  wire restart = frame && !val && miss_n > WW'(VAL_WIN - VAL_NEED);
  wire isnew   = val && !(last_ok && pl == last_pl);

  wire idle_ev = bit_en && bit_in && armed && ones == OW'(IDLE_LEN - 1);

  wire empty = (cnt == '0);
  wire pop   = stat_rd && !empty;
  wire push  = isnew && (cnt != CW'(DEPTH) || pop);
  wire ovf_ev = isnew && !push;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      cand <= '0;
      hit  <= '0;
      tot  <= '0;
    end else if (frame) begin
      sr <= '0;
      if (val) begin
        hit <= '0;
        tot <= '0;
      end else if (restart || tot == '0) begin
        cand <= pl;
        hit  <= WW'(1);
        tot  <= WW'(1);
      end else begin
        hit <= hit_n;
        tot <= tot_n;
      end
    end else if (bit_en) begin
      sr <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones    <= '0;
      armed   <= 1'b0;
      last_ok <= 1'b0;
      last_pl <= '0;
    end else begin
      if (bit_en)
        ones <= !bit_in ? '0 : (ones == OW'(IDLE_LEN)) ? ones : ones + OW'(1);
      if (val) begin
        armed   <= 1'b1;
        last_ok <= 1'b1;
        last_pl <= pl;
      end else if (idle_ev) begin
        armed   <= 1'b0;
        last_ok <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= pl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfd    <= 1'b0;
      idle_f <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      cfd    <= isnew   || (cfd    && !stat_rd);
      idle_f <= idle_ev || (idle_f && !stat_rd);
      ovf    <= ovf_ev  || (ovf    && !stat_rd);
    end
  end

  assign stat = {ovf, empty, empty ? 6'd0 : mem[rp], 6'd0, idle_f, cfd};
  assign irq  = feac_ie && (cfd || (idle_f && idle_ie));
endmodule

// File: rtl/feac_rx_chk.sv
module feac_rx_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          stat_rd,
  input logic          feac_ie,
  input logic          irq,
  input logic          cfd,
  input logic          ovf,
  input logic          isnew,
  input logic          push,
  input logic          pop,
  input logic [CW-1:0] cnt
);
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !isnew) |=> !cfd);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    isnew |=> cfd);

  p_depth_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && cnt == '0 && !push) |=> cnt == '0);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (isnew && cnt == CW'(DEPTH) && !pop) |=> (ovf && cnt == CW'(DEPTH)));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !feac_ie |-> !irq);
endmodule

bind feac_rx feac_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .stat_rd(stat_rd), .feac_ie(feac_ie), .irq(irq),
  .cfd(cfd), .ovf(ovf), .isnew(isnew), .push(push), .pop(pop), .cnt(cnt)
);

// File: tb/tb_feac_rx.sv
module tb_feac_rx;
  logic clk = 0, rst = 1, bit_en = 0, bit_in = 0, stat_rd = 0, idle_ie = 0, feac_ie = 0;
  logic [15:0] stat;
  logic irq;
  int nchk = 0, nerr = 0, rd_pct = 0, gap_pct = 0;
  string phase = "R12";

  feac_rx dut (.clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .stat_rd(stat_rd),
               .idle_ie(idle_ie), .feac_ie(feac_ie), .stat(stat), .irq(irq));

  always #10 clk = ~clk;

  logic [15:0] m_sr;
  logic [5:0]  m_cand, m_lpl;
  logic [5:0]  m_q [4];
  int m_hit, m_tot, m_ones, m_cnt, m_rp;
  bit m_armed, m_lok, m_cfd, m_idl, m_ovf;

  function automatic void m_reset();
    m_sr = 0; m_cand = 0; m_lpl = 0; m_hit = 0; m_tot = 0; m_ones = 0;
    m_cnt = 0; m_rp = 0; m_armed = 0; m_lok = 0; m_cfd = 0; m_idl = 0; m_ovf = 0;
  endfunction

  function automatic void m_step(bit en, bit b, bit rd);
    bit isnew = 0, iev = 0, oev = 0;
    logic [15:0] nx;
    logic [5:0] pl;
    if (en) begin
      nx = {b, m_sr[15:1]};
      pl = nx[14:9];
      iev = b && m_armed && m_ones == 15;
      m_ones = b ? (m_ones < 16 ? m_ones + 1 : 16) : 0;
      if (nx[7:0] == 8'hFF && !nx[8] && !nx[15]) begin
        m_sr = 0;
        if (m_tot == 0) begin m_cand = pl; m_hit = 1; m_tot = 1; end
        else begin m_tot++; if (pl == m_cand) m_hit++; end
        if (m_hit == 8) begin
          isnew = !(m_lok && pl == m_lpl);
          m_lok = 1; m_lpl = pl; m_armed = 1; m_tot = 0; m_hit = 0;
        end else if (m_tot - m_hit > 2) begin
          m_cand = pl; m_hit = 1; m_tot = 1;
        end
      end else m_sr = nx;
      if (iev) begin m_armed = 0; m_lok = 0; end
    end
    if (rd && m_cnt > 0) begin m_rp = (m_rp + 1) % 4; m_cnt--; end
    if (isnew) begin
      if (m_cnt < 4) begin m_q[(m_rp + m_cnt) % 4] = pl; m_cnt++; end
      else oev = 1;
    end
    m_cfd = isnew || (m_cfd && !rd);
    m_idl = iev   || (m_idl && !rd);
    m_ovf = oev   || (m_ovf && !rd);
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s [%s] t=%0t act=%h exp=%h", tag, phase, $time, act, exp);
    end
  endtask

  task automatic check_out();
    logic [15:0] e;
    logic ei;
    e = {m_ovf, m_cnt == 0, (m_cnt == 0) ? 6'd0 : m_q[m_rp], 6'd0, m_idl, m_cfd};
    ei = feac_ie && (m_cfd || (m_idl && idle_ie));
    chk(stat[0] == e[0], "R4 detect", stat, e);
    chk(stat[1] == e[1], "R5 idle", stat, e);
    chk(stat[13:8] == e[13:8], "R1/R7 payload", stat, e);
    chk(stat[14] == e[14], "R6 empty", stat, e);
    chk(stat[15] == e[15], "R8 overflow", stat, e);
    chk(stat[7:2] == 6'd0, "R9 zero bits", stat, e);
    chk(irq == ei, "R10 irq", {15'd0, irq}, {15'd0, ei});
  endtask

  task automatic tick(bit en, bit b, bit rd);
    @(negedge clk);
    bit_en = en; bit_in = b; stat_rd = rd;
    #1;
    check_out();
    m_step(en, b, rd);
  endtask

  function automatic bit rnd_rd();
    return ($urandom % 100) < rd_pct;
  endfunction

  task automatic send_cw(logic [5:0] p, bit last_rd);
    for (int i = 0; i < 16; i++) begin
      bit b;
      b = (i < 8) ? 1'b1 : (i == 8 || i == 15) ? 1'b0 : p[i - 9];
      if (($urandom % 100) < gap_pct) tick(0, $urandom % 2, rnd_rd());
      tick(1, b, (i == 15 && last_rd) ? 1'b1 : rnd_rd());
    end
  endtask

  task automatic send_n(logic [5:0] p, int n);
    for (int k = 0; k < n; k++) send_cw(p, 0);
  endtask

  task automatic ones_run(int n);
    for (int i = 0; i < n; i++) tick(1, 1, rnd_rd());
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) tick(0, 0, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; bit_en = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_reset();
    phase = "R12 after reset";
    #1;
    check_out();
    chk(stat == 16'h4000, "R12 reset state", stat, 16'h4000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    feac_ie = 1; idle_ie = 1;
    do_reset();

    phase = "R1 R2 eight matching";
    send_n(6'b100101, 7);
    tick(0, 0, 0);
    send_cw(6'b100101, 0);
    tick(0, 0, 0);
    phase = "R3 repeat suppressed";
    send_n(6'b100101, 8);
    tick(0, 0, 1);
    phase = "R5 idle run";
    ones_run(18);
    tick(0, 0, 1);
    phase = "R3 same payload after idle";
    send_n(6'b100101, 8);
    drain();

    phase = "R2 tolerance two mismatches";
    send_cw(6'b000111, 0); send_cw(6'b000111, 0); send_cw(6'b111000, 0);
    send_cw(6'b000111, 0); send_cw(6'b000111, 0); send_cw(6'b010101, 0);
    send_n(6'b000111, 4);
    drain();
    phase = "R2 third mismatch restarts";
    send_cw(6'b001100, 0); send_cw(6'b110011, 0); send_cw(6'b110011, 0);
    send_cw(6'b110011, 0); send_n(6'b001100, 6);
    drain();

    phase = "R8 overflow";
    idle_ie = 0;
    send_n(6'd1, 8); send_n(6'd2, 8); send_n(6'd3, 8); send_n(6'd4, 8);
    send_n(6'd5, 8);
    tick(0, 0, 0);
    phase = "R11 push and pop of full fifo";
    send_n(6'd6, 7);
    send_cw(6'd6, 1);
    tick(0, 0, 0);
    drain();
    phase = "R7 empty read";
    tick(0, 0, 1);
    tick(0, 0, 1);

    phase = "R11 detect set while read";
    idle_ie = 1;
    send_n(6'd9, 7);
    send_cw(6'd9, 1);
    tick(0, 0, 0);
    ones_run(15);
    phase = "R11 idle set while read";
    tick(1, 1, 1);
    tick(0, 0, 0);
    feac_ie = 0;
    tick(0, 0, 0);
    feac_ie = 1;
    drain();

    phase = "random";
    for (int it = 0; it < 260; it++) begin
      int a;
      logic [5:0] p;
      rd_pct  = $urandom % 30;
      gap_pct = $urandom % 20;
      idle_ie = $urandom % 2;
      feac_ie = ($urandom % 4) != 0;
      a = $urandom % 10;
      p = 6'($urandom % 3) * 6'd21;
      if (a < 6) send_cw(p, ($urandom % 16) == 0);
      else if (a < 8) ones_run(10 + $urandom % 10);
      else if (a < 9) begin
        send_cw(p, 0);
        for (int i = 0; i < 16; i++) tick(1, $urandom % 2, rnd_rd());
      end else tick(0, 0, 1);
    end

    rd_pct = 0; gap_pct = 0;
    send_n(6'd7, 3);
    do_reset();

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule